// File: doc/BRIEF.md
# SPI Controller with Shared Shift Register

This block is a serial peripheral port that runs either as bus master or as slave. One 8-bit shift register serves both directions. A byte written to the data register goes into the shift register, and received bits shift into the same register from the bottom. A read of the data register returns the live content of the shift register. Characters from 1 to 8 bits are supported. Outgoing characters are placed at the top of the register and incoming ones collect at the bottom.

As master, a data write starts a transfer in SPI mode 0. Data goes out most significant bit first, outputs change when SCK falls, and inputs are sampled when SCK rises. A 16-bit reload count, split over a high byte and a low byte, sets the SCK half-period in system clocks. As slave, a data write only preloads the register. The external master then clocks the transfer while it holds select low. When the port is disabled, the same divider can run as a periodic timer that raises the interrupt.

Top module: `spi_shared_sr`

Register map (`reg_addr_i`): 0 data, 1 control, 2 mode, 3 status, 4 reload high byte, 5 reload low byte. Control bits: 0 port enable, 1 master select, 2 transfer-done interrupt enable, 3 timer enable. Mode bits [2:0] set the character length, where 0 means 8. Status bits: 0 transfer done, 1 overrun, 2 busy (read only), 3 timer expired. Writing 1 to status bits 0, 1 and 3 clears them.

## Requirements
- R1: After reset, status reads 0, irq_o is 0, ss_no is 1 and all four output enables are 0.
- R2: With enable and master set, a data write starts a transfer. ss_no is low while it runs, SCK idles low and toggles every R system clocks (R = reload count), and MOSI presents bit 7, then 6 and so on, changing only when SCK falls.
- R3: The master samples MISO on each rising SCK edge. After n bits the data register reads ((tx << n) | rx) & 0xFF, with rx right-justified. A length field of 0 means 8 bits.
- R4: For n < 8 only tx bits [7:8-n] are sent, so a transmit character is left-justified.
- R5: When the last bit of a character shifts, status bit 0 sets. irq_o follows it when control bit 2 is set. Writing 1 to status bit 0 clears it.
- R6: A data write while a transfer is in progress is dropped and sets status bit 1. The running transfer and its result are unchanged. Writing 1 to status bit 1 clears it.
- R7: In slave mode, a data write only loads the shift register. It drives no SCK, starts nothing, and shifts only on external SCK edges while ss_ni is low. miso_oe_o is 1 only while ss_ni is low.
- R8: In slave mode, ss_ni going high clears the bit counter, so a partial character is abandoned and the next select starts a fresh character.
- R9: With enable clear and control bit 3 set, the divider runs as a timer. Status bit 3 and irq_o set R clocks after the timer starts.
- R10: A reload count of 0 acts as 65536.
- R11: A data register read returns the current shift register content, including a value just loaded in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register select |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |
| irq_o | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from external master |
| sck_o | output | 1 | Serial clock driven as master |
| sck_oe_o | output | 1 | SCK output enable |
| mosi_i | input | 1 | Slave data input |
| mosi_o | output | 1 | Master data output |
| mosi_oe_o | output | 1 | MOSI output enable |
| miso_i | input | 1 | Master data input |
| miso_o | output | 1 | Slave data output |
| miso_oe_o | output | 1 | MISO output enable |
| ss_ni | input | 1 | Slave select from external master, active low |
| ss_no | output | 1 | Slave select driven as master, active low |
| ss_oe_o | output | 1 | SS output enable |

## Verification
The hardest situations to reach are a data write that lands in the middle of a master character, and a slave select dropped after a few bits. The bench reaches the first by issuing a write from inside its clock-by-clock comparison loop. It then keeps comparing SCK, MOSI and select against its model to show that the transfer goes on untouched. It reaches the second by clocking three bits, raising ss_ni and then sending a full new character, whose value must come back whole. The 65536-cycle period for a zero reload is reached by running the timer through the full count.

// File: rtl/spi_ssr_pkg.sv
package spi_ssr_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MODE  = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_RLDHI = 3'd4;
  localparam logic [ADDR_W-1:0] A_RLDLO = 3'd5;

  typedef struct packed {
    logic tmr_en;
    logic tc_ie;
    logic master;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/spi_ssr_baud.sv
module spi_ssr_baud #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  // reload 0 wraps to all ones: full 2^CNT_W period
  assign last   = reload_i - 1'b1;
  assign tick_o = run_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  a_r10_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && reload_i != CNT_W'(1)) |=> !tick_o);
endmodule

// File: rtl/spi_ssr_shift.sv
module spi_ssr_shift #(
  parameter int DW = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    master_i,
  input  logic [$clog2(DW)-1:0]   nbits_i,
  input  logic                    load_i,
  input  logic [DW-1:0]           load_data_i,
  input  logic                    tick_i,
  input  logic                    miso_i,
  input  logic                    sck_i,
  input  logic                    mosi_i,
  input  logic                    ss_ni,
  output logic [DW-1:0]           sr_o,
  output logic                    m_busy_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    sck_o,
  output logic                    sel_o
);
  localparam int CW = $clog2(DW);

  logic [DW-1:0] sr_q;
  logic [CW-1:0] bitcnt_q, last_idx;
  logic          m_busy_q, sck_q, samp_q;
  logic [2:0]    sck_s;
  logic [1:0]    mosi_s, ss_s;
  logic          start, m_rise, m_fall, s_rise, s_fall, shift_ev, samp_ev, samp_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_s  <= '0;
      mosi_s <= '0;
      ss_s   <= '1;
    end else begin
      sck_s  <= {sck_s[1:0], sck_i};
      mosi_s <= {mosi_s[0], mosi_i};
      ss_s   <= {ss_s[0], ss_ni};
    end
  end

  assign last_idx = (nbits_i == '0) ? CW'(DW-1) : nbits_i - 1'b1;
  assign sel_o    = en_i && !master_i && !ss_s[1];
  assign start    = load_i && en_i && master_i;
  assign m_rise   = m_busy_q && tick_i && !sck_q;
  assign m_fall   = m_busy_q && tick_i && sck_q;
  assign s_rise   = sel_o && sck_s[1] && !sck_s[2];
  assign s_fall   = sel_o && !sck_s[1] && sck_s[2];
  assign shift_ev = m_fall || s_fall;
  assign samp_ev  = m_rise || s_rise;
  assign samp_bit = master_i ? miso_i : mosi_s[1];
  assign done_o   = shift_ev && (bitcnt_q == last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      bitcnt_q <= '0;
      m_busy_q <= 1'b0;
      sck_q    <= 1'b0;
      samp_q   <= 1'b0;
    end else if (load_i) begin
      sr_q     <= load_data_i;
      bitcnt_q <= '0;
      sck_q    <= 1'b0;
      if (start) m_busy_q <= 1'b1;
    end else if (!en_i) begin
      m_busy_q <= 1'b0;
      sck_q    <= 1'b0;
      bitcnt_q <= '0;
    end else begin
      if (samp_ev) samp_q <= samp_bit;
      if (m_rise || m_fall) sck_q <= ~sck_q;
      if (shift_ev) begin
        sr_q     <= {sr_q[DW-2:0], samp_q};
        bitcnt_q <= done_o ? '0 : bitcnt_q + 1'b1;
        if (m_fall && done_o) m_busy_q <= 1'b0;
      end else if (!m_busy_q && (ss_s[1] || master_i)) begin
        bitcnt_q <= '0;
      end
    end
  end

  assign sr_o     = sr_q;
  assign m_busy_o = m_busy_q;
  assign busy_o   = m_busy_q || sel_o;
  assign sck_o    = sck_q;

  a_r2_sck_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_busy_q |-> !sck_q);
  a_r8_ss_clears_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !master_i && ss_s[1] && !m_busy_q && !load_i) |=> (bitcnt_q == '0));
endmodule

// File: rtl/spi_shared_sr.sv
module spi_shared_sr
  import spi_ssr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  reg_addr_i,
  input  logic        reg_we_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  output logic        irq_o,
  input  logic        sck_i,
  output logic        sck_o,
  output logic        sck_oe_o,
  input  logic        mosi_i,
  output logic        mosi_o,
  output logic        mosi_oe_o,
  input  logic        miso_i,
  output logic        miso_o,
  output logic        miso_oe_o,
  input  logic        ss_ni,
  output logic        ss_no,
  output logic        ss_oe_o
);
  localparam int NB_W = $clog2(REG_W);

  ctrl_t           ctrl_q;
  logic [NB_W-1:0] nbits_q;
  logic [7:0]      rld_hi_q, rld_lo_q;
  logic            tc_q, ovr_q, tmr_q;
  logic            data_we, stat_we, load, busy, m_busy, done, tick, tmr_run, sel;
  logic [REG_W-1:0] sr;

  assign data_we = reg_we_i && (reg_addr_i == A_DATA);
  assign stat_we = reg_we_i && (reg_addr_i == A_STAT);
  assign load    = data_we && !busy;
  assign tmr_run = !ctrl_q.en && ctrl_q.tmr_en;

  spi_ssr_baud #(.CNT_W(16)) u_baud (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (m_busy || tmr_run),
    .reload_i ({rld_hi_q, rld_lo_q}),
    .tick_o   (tick)
  );

  spi_ssr_shift #(.DW(REG_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (ctrl_q.en),
    .master_i    (ctrl_q.master),
    .nbits_i     (nbits_q),
    .load_i      (load),
    .load_data_i (reg_wdata_i),
    .tick_i      (tick),
    .miso_i      (miso_i),
    .sck_i       (sck_i),
    .mosi_i      (mosi_i),
    .ss_ni       (ss_ni),
    .sr_o        (sr),
    .m_busy_o    (m_busy),
    .busy_o      (busy),
    .done_o      (done),
    .sck_o       (sck_o),
    .sel_o       (sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      nbits_q  <= '0;
      rld_hi_q <= '0;
      rld_lo_q <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        A_CTRL:  ctrl_q   <= reg_wdata_i[3:0];
        A_MODE:  nbits_q  <= reg_wdata_i[NB_W-1:0];
        A_RLDHI: rld_hi_q <= reg_wdata_i;
        A_RLDLO: rld_lo_q <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  // status flags: set wins over write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q  <= 1'b0;
      ovr_q <= 1'b0;
      tmr_q <= 1'b0;
    end else begin
      if (done)                           tc_q  <= 1'b1;
      else if (stat_we && reg_wdata_i[0]) tc_q  <= 1'b0;
      if (data_we && busy)                ovr_q <= 1'b1;
      else if (stat_we && reg_wdata_i[1]) ovr_q <= 1'b0;
      if (tick && tmr_run)                tmr_q <= 1'b1;
      else if (stat_we && reg_wdata_i[3]) tmr_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr_i)
      A_DATA:  reg_rdata_o = sr;
      A_CTRL:  reg_rdata_o = {4'b0, ctrl_q};
      A_MODE:  reg_rdata_o = 8'(nbits_q);
      A_STAT:  reg_rdata_o = {4'b0, tmr_q, busy, ovr_q, tc_q};
      A_RLDHI: reg_rdata_o = rld_hi_q;
      A_RLDLO: reg_rdata_o = rld_lo_q;
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o     = (tc_q && ctrl_q.tc_ie) || tmr_q;
  assign sck_oe_o  = ctrl_q.en && ctrl_q.master;
  assign mosi_oe_o = ctrl_q.en && ctrl_q.master;
  assign ss_oe_o   = ctrl_q.en && ctrl_q.master;
  assign ss_no     = !m_busy;
  assign mosi_o    = sr[REG_W-1];
  assign miso_o    = sr[REG_W-1];
  assign miso_oe_o = sel;

  a_r5_tc_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> tc_q);
  a_r6_ovr_on_busy_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we && busy) |=> ovr_q);
  a_r6_busy_write_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we && m_busy) |=> m_busy || tc_q);
  a_r9_timer_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && tmr_run) |=> (tmr_q && irq_o));
endmodule

// File: tb/tb_spi_shared_sr.sv
module tb_spi_shared_sr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, sck_i, sck_o, sck_oe, mosi_i, mosi_o, mosi_oe;
  logic       miso_i, miso_o, miso_oe, ss_ni, ss_no, ss_oe;
  int         errors = 0;
  int         checks = 0;
  bit         finished = 0;

  always #2.5 clk = ~clk;

  spi_shared_sr dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_we_i(reg_we),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe_o(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe_o(miso_oe),
    .ss_ni(ss_ni), .ss_no(ss_no), .ss_oe_o(ss_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // master transfer with per-clock model of SCK, MOSI, select
  task automatic mtx(input logic [7:0] tx, input logic [7:0] rx, input int n,
                     input int r, input int ovr_at);
    int nn;
    logic [7:0] v, d;
    nn = (n == 0) ? 8 : n;
    v  = rx & 8'((1 << nn) - 1);
    wr(3'd0, tx);
    for (int t = 1; t <= 2*nn*r; t++) begin
      int b;
      b = (t - 1) / (2*r);
      miso_i = v[nn-1-b];
      if (t == ovr_at) begin
        reg_addr = 3'd0; reg_wdata = ~tx; reg_we = 1'b1;
      end
      @(posedge clk); #1;
      reg_we = 1'b0;
      chk("R2 sck", int'(sck_o), (t / r) % 2);
      chk("R2 ss_no", int'(ss_no), (t == 2*nn*r) ? 1 : 0);
      if (t < 2*nn*r) chk("R2 R4 mosi", int'(mosi_o), int'(tx[7 - t/(2*r)]));
    end
    rd(3'd0, d);
    chk("R3 rx data", int'(d), int'(8'((int'(tx) << nn) | int'(v))));
    rd(3'd3, d);
    chk("R5 tc set", int'(d[0]), 1);
    chk("R2 busy clear", int'(d[2]), 0);
  endtask

  // external master clocks cnt bits of rx; optional MISO check vs txe
  task automatic sbits(input logic [7:0] rx, input int cnt, input logic [7:0] txe, input bit chkm);
    for (int b = 0; b < cnt; b++) begin
      mosi_i = rx[7-b];
      cycles(8);
      if (chkm) chk("R7 miso bit", int'(miso_o), int'(txe[7-b]));
      sck_i = 1'b1;
      cycles(8);
      sck_i = 1'b0;
      cycles(8);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    sck_i = 0; mosi_i = 0; miso_i = 0; ss_ni = 1;
    cycles(3);
    @(negedge clk); rst_n = 1'b1;
    cycles(1);

    // R1
    rd(3'd3, d);
    chk("R1 status", int'(d), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 ss_no", int'(ss_no), 1);
    chk("R1 oe", int'({sck_oe, mosi_oe, miso_oe, ss_oe}), 0);

    // R2 R3: 8-bit master, R=2, length field 0
    wr(3'd4, 8'h00); wr(3'd5, 8'h02); wr(3'd2, 8'h00); wr(3'd1, 8'h03);
    chk("R2 master oe", int'({sck_oe, mosi_oe, ss_oe}), 7);
    mtx(8'hA5, 8'h3C, 0, 2, 0);
    wr(3'd3, 8'h01);

    // R4: 4-bit characters, R=3
    wr(3'd2, 8'h04); wr(3'd5, 8'h03);
    mtx(8'hB0, 8'h09, 4, 3, 0);
    wr(3'd3, 8'h01);
    rd(3'd3, d);
    chk("R5 tc w1c", int'(d[0]), 0);

    // R5: interrupt on done, R=1, 5 bits
    wr(3'd1, 8'h07); wr(3'd5, 8'h01); wr(3'd2, 8'h05);
    chk("R5 irq idle", int'(irq), 0);
    mtx(8'h5A, 8'h11, 5, 1, 0);
    chk("R5 irq", int'(irq), 1);
    wr(3'd3, 8'h01);
    chk("R5 irq cleared", int'(irq), 0);

    // R6: overrun mid-transfer
    wr(3'd1, 8'h03); wr(3'd2, 8'h00); wr(3'd5, 8'h02);
    mtx(8'hC3, 8'h7E, 8, 2, 5);
    rd(3'd3, d);
    chk("R6 ovr set", int'(d[1]), 1);
    wr(3'd3, 8'h03);
    rd(3'd3, d);
    chk("R6 ovr w1c", int'(d[1]), 0);

    // R7 R11: slave mode
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h96);
    cycles(2);
    rd(3'd0, d);
    chk("R11 slave load readback", int'(d), 8'h96);
    rd(3'd3, d);
    chk("R7 no start", int'(d[2]), 0);
    chk("R7 no sck drive", int'({sck_oe, sck_o, mosi_oe, ss_oe}), 0);
    chk("R7 miso_oe ss high", int'(miso_oe), 0);
    ss_ni = 1'b0;
    cycles(8);
    chk("R7 miso_oe ss low", int'(miso_oe), 1);
    sbits(8'h4D, 8, 8'h96, 1'b1);
    rd(3'd0, d);
    chk("R7 slave rx", int'(d), 8'h4D);
    rd(3'd3, d);
    chk("R7 slave tc", int'(d[0]), 1);
    wr(3'd0, 8'hFF);
    rd(3'd3, d);
    chk("R6 slave ovr", int'(d[1]), 1);
    rd(3'd0, d);
    chk("R6 slave data kept", int'(d), 8'h4D);
    ss_ni = 1'b1;
    cycles(8);
    chk("R7 miso_oe released", int'(miso_oe), 0);

    // R8: partial character abandoned on deselect
    wr(3'd3, 8'h03);
    ss_ni = 1'b0; cycles(8);
    sbits(8'hE0, 3, 8'h00, 1'b0);
    ss_ni = 1'b1; cycles(8);
    rd(3'd3, d);
    chk("R8 no tc partial", int'(d[0]), 0);
    ss_ni = 1'b0; cycles(8);
    sbits(8'h2B, 7, 8'h00, 1'b0);
    rd(3'd3, d);
    chk("R8 no tc after 7 fresh bits", int'(d[0]), 0);
    sbits(8'h2B << 7, 1, 8'h00, 1'b0);
    rd(3'd0, d);
    chk("R8 fresh char", int'(d), 8'h2B);
    rd(3'd3, d);
    chk("R8 tc after full char", int'(d[0]), 1);
    ss_ni = 1'b1; cycles(8);
    wr(3'd3, 8'h03);

    // R9: timer mode, R=4
    wr(3'd1, 8'h00); wr(3'd4, 8'h00); wr(3'd5, 8'h04);
    wr(3'd1, 8'h08);
    for (int t = 1; t <= 4; t++) begin
      @(posedge clk); #1;
      chk("R9 timer irq", int'(irq), (t == 4) ? 1 : 0);
    end
    wr(3'd3, 8'h08);
    rd(3'd3, d);
    chk("R9 timer w1c", int'(d[3]), 0);
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h08);

    // R10: reload 0 = 65536
    wr(3'd5, 8'h00);
    wr(3'd1, 8'h08);
    for (int t = 1; t <= 65536; t++) begin
      @(posedge clk); #1;
      if (t == 65535) chk("R10 not yet", int'(irq), 0);
      if (t == 65536) chk("R10 full period", int'(irq), 1);
    end
    wr(3'd1, 8'h00);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule